// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

This block supervises a running system by watching one chosen bit of a free-running time-base count. Each time that bit goes from 0 to 1, the block counts a timeout. Timeouts move the block up a short escalation ladder, one step per timeout:

- The first timeout arms the watchdog.
- The second timeout marks an interrupt as pending.
- A further timeout, arriving while that interrupt is still unacknowledged, requests a hardware reset.

Software configures the block through a single register write port. This port reaches two registers: a control word and a status mask. The control word selects the period, enables the interrupt and sets a reset-control code. Once the reset-control code is non-zero, software cannot clear it again. The status mask is write-one-to-clear: software uses it to acknowledge the pending interrupt or to disarm the watchdog.

The time-base counter, the reset circuitry that acts on the request, and the processor are all outside the block. The block sees only the time-base value, a global critical-interrupt enable and the write port. It drives an interrupt request, a one-cycle reset request and the reset-control code that goes with that request.

Top module: `wdt_two_stage`

## Requirements
- R1: After system reset the interrupt request, the reset request and the reported reset code are all 0, and the reset-control field holds 00.
- R2: A timeout is a 0-to-1 change of the time-base bit at index BASE_EXP-1+STEP*code, where code is the period field, control-write bits [1:0]. With the defaults this gives periods of 2^17, 2^21, 2^25 and 2^29 time-base clocks. Changes on any other bit do nothing.
- R3: A timeout while the enable-next flag is 0 sets that flag and does nothing else.
- R4: A timeout while the enable-next flag is 1 and the pending flag is 0 sets the pending flag.
- R5: The interrupt request equals pending AND interrupt-enable AND the global critical-interrupt enable. Interrupt-enable is control-write bit [2].
- R6: A timeout while both flags are 1 and the reset-control field is non-zero drives the reset request high for exactly one cycle. The reported code equals the field during that cycle and is 00 otherwise. Both flags keep their values.
- R7: While the reset-control field is 00, a timeout with both flags set produces no reset request.
- R8: A status write (select 1) is a mask. Bit [0] = 1 clears the enable-next flag and bit [1] = 1 clears the pending flag. A 0 bit leaves its flag unchanged. A timeout that sets a flag in the same cycle wins over the clear.
- R9: The reset-control field is control-write bits [4:3]. A control write (select 0) loads it only while it holds 00. Once it is non-zero, further writes leave it unchanged until system reset.
- R10: In the first cycle after the period field changes, no timeout is detected, even when the newly selected bit is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbase_i | input | TB_W | Free-running time-base value |
| crit_en_i | input | 1 | Global critical-interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the control word, 1 selects the status clear mask |
| wr_data_i | input | 5 | Write data |
| irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 1 | One-cycle hardware reset request |
| rst_code_o | output | 2 | Reset-control code reported with the reset request |

## Verification
The two status flags are not visible at the ports, so a wrong flag value shows up only at the next timeout. One timeout too many or too few moves the interrupt to the wrong pulse. It can also turn an expected reset request into none, or produce one that should not occur. A false edge after a period change is exposed the same way: the interrupt rises one real timeout early. A broken sticky reset-control field shows up at the next reset request as a wrong or missing code, one cycle after the triggering edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int WR_W      = 5;
  localparam int MASK_ARM  = 0;
  localparam int MASK_PEND = 1;
  localparam int NUM_SEL   = 4;

  typedef logic [1:0] per_t;
  typedef logic [1:0] rc_t;

  typedef struct packed {
    rc_t  rc;
    logic ie;
    per_t per;
  } ctl_t;

endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ctl_i,
  input  ctl_t data_i,
  output per_t per_o,
  output logic ie_o,
  output rc_t  rc_o,
  output logic per_chg_o
);

  ctl_t ctl_q, ctl_d;
  logic chg_q, chg_d;

  always_comb begin
    ctl_d = ctl_q;
    chg_d = 1'b0;
    if (wr_ctl_i) begin
      ctl_d.per = data_i.per;
      ctl_d.ie  = data_i.ie;
      if (ctl_q.rc == 2'b00) begin
        ctl_d.rc = data_i.rc;
      end
      chg_d = (data_i.per != ctl_q.per);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_ctl_i) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
    end
  end

  assign per_o     = ctl_q.per;
  assign ie_o      = ctl_q.ie;
  assign rc_o      = ctl_q.rc;
  assign per_chg_o = chg_q;

  AST_RC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.rc != 2'b00) |=> (ctl_q.rc == $past(ctl_q.rc))); // R9

endmodule

// File: rtl/wdt_edge_sel.sv
module wdt_edge_sel
  import wdt_pkg::*;
#(
  parameter int TB_W     = 64,
  parameter int BASE_EXP = 17,
  parameter int STEP     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tbase_i,
  input  per_t            per_i,
  input  logic            per_chg_i,
  output logic            tmo_o
);

  localparam int BIT0 = BASE_EXP - 1;

  logic [NUM_SEL-1:0] cand;
  logic cur_bit;
  logic prev_q, prev_d;
  logic tb_unused;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_cand
    assign cand[g] = tbase_i[BIT0 + STEP * g];
  end

  assign tb_unused = ^tbase_i;

  always_comb begin
    cur_bit = cand[per_i];
    prev_d  = cur_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign tmo_o = cur_bit & ~prev_q & ~per_chg_i;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !tmo_o); // R2

endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tmo_i,
  input  logic       clr_wr_i,
  input  logic [1:0] clr_mask_i,
  input  logic       ie_i,
  input  logic       crit_i,
  input  rc_t        rc_i,
  output logic       irq_o,
  output logic       rst_req_o,
  output rc_t        rst_code_o
);

  logic arm_q, arm_d;
  logic pend_q, pend_d;
  logic fire;
  logic req_q;
  rc_t  code_q, code_d;
  logic flag_en;

  always_comb begin
    arm_d  = arm_q;
    pend_d = pend_q;
    fire   = 1'b0;
    if (clr_wr_i) begin
      arm_d  = arm_q  & ~clr_mask_i[MASK_ARM];
      pend_d = pend_q & ~clr_mask_i[MASK_PEND];
    end
    if (tmo_i) begin
      if (!arm_q) begin
        arm_d = 1'b1;
      end else if (!pend_q) begin
        pend_d = 1'b1;
      end else begin
        fire = (rc_i != 2'b00);
      end
    end
    code_d  = fire ? rc_i : 2'b00;
    flag_en = clr_wr_i | tmo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (flag_en) begin
      arm_q  <= arm_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      code_q <= 2'b00;
    end else begin
      req_q  <= fire;
      code_q <= code_d;
    end
  end

  assign irq_o      = pend_q & ie_i & crit_i;
  assign rst_req_o  = req_q;
  assign rst_code_o = code_q;

  AST_ARM_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_q) |-> $past(tmo_i)); // R3

  AST_PEND_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(tmo_i && arm_q)); // R4

  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6

  AST_RST_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_code_o != 2'b00)); // R7

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int TB_W     = 64,
  parameter int BASE_EXP = 17,
  parameter int STEP     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tbase_i,
  input  logic            crit_en_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            irq_o,
  output logic            rst_req_o,
  output logic [1:0]      rst_code_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       wr_ctl, wr_clr;
  per_t       per;
  logic       ie;
  rc_t        rc;
  logic       per_chg;
  logic       tmo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];
  assign wr_ctl    = wr_en_i & ~wr_sel_i;
  assign wr_clr    = wr_en_i &  wr_sel_i;

  wdt_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_ctl_i  (wr_ctl),
    .data_i    (ctl_t'(wr_data_i)),
    .per_o     (per),
    .ie_o      (ie),
    .rc_o      (rc),
    .per_chg_o (per_chg)
  );

  wdt_edge_sel #(
    .TB_W     (TB_W),
    .BASE_EXP (BASE_EXP),
    .STEP     (STEP)
  ) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .tbase_i   (tbase_i),
    .per_i     (per),
    .per_chg_i (per_chg),
    .tmo_o     (tmo)
  );

  wdt_escalate u_esc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .tmo_i      (tmo),
    .clr_wr_i   (wr_clr),
    .clr_mask_i (wr_data_i[1:0]),
    .ie_i       (ie),
    .crit_i     (crit_en_i),
    .rc_i       (rc),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .rst_code_o (rst_code_o)
  );

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    irq_o |-> crit_en_i); // R5

endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;

  localparam int TB_W = 8;

  typedef struct {
    string      req;
    logic       irq;
    logic       rr;
    logic [1:0] code;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TB_W-1:0] tbase = '0;
  logic            crit_en = 1'b1;
  logic            wr_en = 1'b0;
  logic            wr_sel = 1'b0;
  logic [4:0]      wr_data = '0;
  logic            irq, rst_req;
  logic [1:0]      rst_code;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  wdt_two_stage #(.TB_W(TB_W), .BASE_EXP(3), .STEP(1)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tbase_i    (tbase),
    .crit_en_i  (crit_en),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .irq_o      (irq),
    .rst_req_o  (rst_req),
    .rst_code_o (rst_code)
  );

  // monitor: compares each expected item against the ports
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      total++;
      if (irq !== e.irq || rst_req !== e.rr || rst_code !== e.code) begin
        bad++;
        $display("FAIL %s: actual irq=%0b rst=%0b code=%0d expected irq=%0b rst=%0b code=%0d",
                 e.req, irq, rst_req, rst_code, e.irq, e.rr, e.code);
      end
    end
  end

  task automatic expect_out(input string req, input logic i, input logic r, input logic [1:0] c);
    exp_t e;
    e.req = req; e.irq = i; e.rr = r; e.code = c;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input int b);
    tbase[b] = 1'b0;
    @(negedge clk);
    tbase[b] = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tbase = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_out("R1 reset", 0, 0, 2'd0);

    wr(1'b0, 5'b10100);                 // rc=2, ie=1, period 0 (bit 2)
    pulse(2); expect_out("R3 first timeout arms only", 0, 0, 2'd0);
    pulse(2); expect_out("R4 second timeout pends", 1, 0, 2'd0);
    crit_en = 1'b0; #1; expect_out("R5 global enable off", 0, 0, 2'd0);
    crit_en = 1'b1; #1; expect_out("R5 global enable on", 1, 0, 2'd0);

    wr(1'b1, 5'b00010); expect_out("R8 clear pending", 0, 0, 2'd0);
    pulse(2); expect_out("R8 zero mask bit kept enable-next", 1, 0, 2'd0);
    pulse(2); expect_out("R6 reset request", 1, 1, 2'd2);
    @(negedge clk); expect_out("R6 request lasts one cycle", 1, 0, 2'd0);

    wr(1'b0, 5'b00100);
    wr(1'b0, 5'b11100);
    pulse(2); expect_out("R9 field kept after writes", 1, 1, 2'd2);

    wr(1'b1, 5'b00001);
    pulse(2); expect_out("R3 re-arm with pending set", 1, 0, 2'd0);
    pulse(2); expect_out("R6 reset after re-arm", 1, 1, 2'd2);
    wr(1'b0, 5'b00000); expect_out("R5 interrupt enable off", 0, 0, 2'd0);

    do_reset();
    expect_out("R1 reset again", 0, 0, 2'd0);
    wr(1'b0, 5'b00100);                 // rc=0, ie=1, period 0
    pulse(2); pulse(2); expect_out("R4 pending", 1, 0, 2'd0);
    pulse(2); expect_out("R7 no reset with field 00", 1, 0, 2'd0);
    @(negedge clk); expect_out("R7 still no reset", 1, 0, 2'd0);

    wr(1'b1, 5'b00011); expect_out("R8 clear both", 0, 0, 2'd0);
    @(negedge clk);
    tbase[2] = 1'b0; tbase[3] = 1'b1;
    @(negedge clk);
    wr(1'b0, 5'b00101);                 // period 1 (bit 3), already high
    @(negedge clk); expect_out("R10 no edge on period change", 0, 0, 2'd0);
    pulse(3); expect_out("R10 first real edge only arms", 0, 0, 2'd0);
    pulse(3); expect_out("R2 new bit pends", 1, 0, 2'd0);

    wr(1'b0, 5'b01101);                 // load rc=1 while 00
    pulse(2); expect_out("R2 other bit ignored", 1, 0, 2'd0);
    pulse(3); expect_out("R9 loaded code reported", 1, 1, 2'd1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule